// File: doc/BRIEF.md
# Flash Sector Protection and Command Register Block

This block is the control and status front end of a serial NOR flash controller. Software reaches it through a small word-addressed register bus. It holds the block-protect setting and exposes it as a status word. It decodes writes to a memory-operation register into bulk-erase, sector-erase and protect-update commands. From the protect setting it derives one protected region. The region is a power-of-two number of 64 KiB sectors, anchored at either the bottom or the top of the device.

Every erase command is checked against the protected region before it is issued. So is every data-write address seen on the memory window. A legal erase leaves the block as a request pulse, one cycle wide, carrying the sector number or a bulk flag; the transfer engine behind the block consumes it. A rejected erase or write raises a sticky error flag, which software clears by writing a one to it. The flags are masked into a single interrupt line. The device size follows from the low byte of the device-ID parameter: 2^(id−6) bytes. The defaults give an 8-sector, 512 KiB device.

Top module: `fprot_csr`

## Requirements
- R1: Register word offsets are fixed: 0 status, 1 silicon ID, 2 device ID, 3 memory-operation (reads 0), 4 interrupt status, 5 interrupt mask (2 bits), 6 chip select (read/write, CS_W bits); offset 7 reads 0, and reads return 0 when bus_sel is low.
- R2: The status word shows protect level bits 2:0 at bits 4:2, level bit 3 at bit 6 and the top/bottom flag at bit 5; all other bits read 0.
- R3: A memory-operation write whose bits 7:0 equal 3 loads the protect level from bits 11:8 and the top/bottom flag from bit 12; level 0 removes all protection.
- R4: Level 0 protects no sector; level p>0 protects 2^(p−1) sectors, clamped to the whole device.
- R5: With the top/bottom flag at 0 the protected sectors are the highest ones of the device; with it at 1 they start at sector 0.
- R6: A memory-operation write with bits 7:0 equal to 2 and an unprotected sector index in bits 8 upward (SECT_W bits) gives req_valid high for exactly the one cycle after the write edge, with req_bulk low and req_sector equal to the index.
- R7: A sector erase that targets a protected sector issues no request and sets interrupt status bit 0.
- R8: A memory-operation write with bits 7:0 equal to 1 issues a request with req_bulk high only when the protect level is 0; otherwise it sets interrupt status bit 0 and issues nothing.
- R9: While dw_valid is high, dw_ok is high exactly when the sector of dw_addr (the bits above the 16 sector-offset bits) is unprotected. A blocked write sets interrupt status bit 1 at the next edge.
- R10: Interrupt status bits stay set until a bus write to offset 4 carries a one in that bit position. A new violation in the same cycle as the clear keeps the bit set.
- R11: irq is high when any interrupt status bit is set together with its mask bit.
- R12: After reset the protect level, flag, interrupt status, mask and chip select are all 0 and req_valid is low.
- R13: Memory-operation writes with any other value in bits 7:0 change nothing and issue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write qualifier for a register access |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| dw_valid | input | 1 | Data write on the memory window this cycle |
| dw_addr | input | ADDR_W | Byte address of that data write |
| dw_ok | output | 1 | Data write allowed |
| req_valid | output | 1 | One-cycle erase request |
| req_bulk | output | 1 | Request is a whole-device erase |
| req_sector | output | SECT_W | Sector to erase |
| chip_sel | output | CS_W | Chip select register value |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest cases to reach are the clamped, top-anchored regions. In these a single level change moves the lower bound across several sectors, and a sector just outside the region must still produce a request. The bench sweeps every level for both anchors. For each setting it erases every sector and writes the first and last byte of every sector, so each region boundary is hit from both sides. A data-write violation is driven in the same cycle as a clear of its flag, to show that the set takes priority.

// File: rtl/fprot_pkg.sv
package fprot_pkg;

  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_SID   = 3'd1,
    REG_DID   = 3'd2,
    REG_MEMOP = 3'd3,
    REG_ISR   = 3'd4,
    REG_IMR   = 3'd5,
    REG_CS    = 3'd6
  } reg_off_e;

  localparam logic [7:0] OP_BULK = 8'd1;
  localparam logic [7:0] OP_SECT = 8'd2;
  localparam logic [7:0] OP_PROT = 8'd3;

  localparam int ISR_ERASE = 0;
  localparam int ISR_WRITE = 1;
  localparam int ISR_W     = 2;

  typedef struct packed {
    logic [3:0] level;
    logic       tb;
  } prot_t;

endpackage

// File: rtl/fprot_range.sv
module fprot_range
  import fprot_pkg::*;
#(
  parameter int SECT_W = 3,
  parameter int N_CHK  = 2
) (
  input  prot_t                          prot,
  input  logic [N_CHK-1:0][SECT_W-1:0]   chk_sect,
  output logic [N_CHK-1:0]               chk_hit,
  output logic [SECT_W:0]                lo,
  output logic [SECT_W:0]                hi
);

  localparam logic [SECT_W:0] NSECT = {1'b1, {SECT_W{1'b0}}};

  logic [SECT_W:0] len;

  // region length in sectors, then placement at bottom or top
  always_comb begin
    if (prot.level == 4'd0) begin
      len = '0;
    end else if ((int'(prot.level) - 1) >= SECT_W) begin
      len = NSECT;
    end else begin
      len = (SECT_W+1)'(1) << (prot.level - 4'd1);
    end
    if (prot.tb) begin
      lo = '0;
      hi = len;
    end else begin
      lo = NSECT - len;
      hi = NSECT;
    end
  end

  for (genvar g = 0; g < N_CHK; g++) begin : g_chk
    assign chk_hit[g] = ({1'b0, chk_sect[g]} >= lo) && ({1'b0, chk_sect[g]} < hi);
  end

endmodule

// File: rtl/fprot_memop.sv
module fprot_memop
  import fprot_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              er_hit,
  output logic [SECT_W-1:0] sect_field,
  output prot_t             prot_q,
  output logic              erase_viol,
  output logic              req_valid_q,
  output logic              req_bulk_q,
  output logic [SECT_W-1:0] req_sect_q
);

  logic [7:0]        op;
  prot_t             prot_d;
  logic              prot_en;
  logic              issue;
  logic              bulk_d;
  logic [SECT_W-1:0] sect_d;
  logic              unused_wdata;

  assign op           = wdata[7:0];
  assign sect_field   = wdata[8 +: SECT_W];
  assign unused_wdata = ^wdata;

  // next-state decode of a memory-operation write
  always_comb begin
    prot_d     = prot_q;
    prot_en    = 1'b0;
    issue      = 1'b0;
    bulk_d     = 1'b0;
    sect_d     = '0;
    erase_viol = 1'b0;
    if (wr_en) begin
      unique case (op)
        OP_PROT: begin
          prot_en      = 1'b1;
          prot_d.level = wdata[11:8];
          prot_d.tb    = wdata[12];
        end
        OP_SECT: begin
          if (er_hit) begin
            erase_viol = 1'b1;
          end else begin
            issue  = 1'b1;
            sect_d = sect_field;
          end
        end
        OP_BULK: begin
          if (prot_q.level != 4'd0) begin
            erase_viol = 1'b1;
          end else begin
            issue  = 1'b1;
            bulk_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q      <= '0;
      req_valid_q <= 1'b0;
      req_bulk_q  <= 1'b0;
      req_sect_q  <= '0;
    end else begin
      req_valid_q <= issue;
      if (prot_en) begin
        prot_q <= prot_d;
      end
      if (issue) begin
        req_bulk_q <= bulk_d;
        req_sect_q <= sect_d;
      end
    end
  end

  // R8: a bulk request only leaves while nothing is protected
  a_r8_bulk_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_q && req_bulk_q) |-> (prot_q.level == 4'd0));

  // R3: protect setting only moves on a memory-operation write
  a_r3_prot_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $past(wr_en));

endmodule

// File: rtl/fprot_csr.sv
module fprot_csr
  import fprot_pkg::*;
#(
  parameter int          SECTOR_LOG2 = 16,
  parameter logic [31:0] SID         = 32'h0000_0017,
  parameter logic [31:0] DEVID       = 32'h0000_0019,
  parameter int          CS_W        = 3,
  localparam int         ADDR_W      = int'(DEVID[7:0]) - 6,
  localparam int         SECT_W      = ADDR_W - SECTOR_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dw_valid,
  input  logic [ADDR_W-1:0] dw_addr,
  output logic              dw_ok,
  output logic              req_valid,
  output logic              req_bulk,
  output logic [SECT_W-1:0] req_sector,
  output logic [CS_W-1:0]   chip_sel,
  output logic              irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  // register-write strobes
  logic wr_memop, wr_isr, wr_imr, wr_cs;
  assign wr_memop = bus_sel && bus_wr && (bus_addr == REG_MEMOP);
  assign wr_isr   = bus_sel && bus_wr && (bus_addr == REG_ISR);
  assign wr_imr   = bus_sel && bus_wr && (bus_addr == REG_IMR);
  assign wr_cs    = bus_sel && bus_wr && (bus_addr == REG_CS);

  // command decode
  prot_t             prot;
  logic [SECT_W-1:0] sect_field;
  logic              er_hit;
  logic              erase_viol;

  fprot_memop #(.SECT_W(SECT_W)) u_memop (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (wr_memop),
    .wdata       (bus_wdata),
    .er_hit      (er_hit),
    .sect_field  (sect_field),
    .prot_q      (prot),
    .erase_viol  (erase_viol),
    .req_valid_q (req_valid),
    .req_bulk_q  (req_bulk),
    .req_sect_q  (req_sector)
  );

  // protected range and the two checks against it
  logic [1:0][SECT_W-1:0] chk_sect;
  logic [1:0]             chk_hit;
  logic [SECT_W:0]        prot_lo, prot_hi;
  logic                   wr_hit;
  logic                   unused_addr;

  assign chk_sect[0] = sect_field;
  assign chk_sect[1] = dw_addr[ADDR_W-1:SECTOR_LOG2];
  assign er_hit      = chk_hit[0];
  assign wr_hit      = chk_hit[1];
  assign unused_addr = ^dw_addr[SECTOR_LOG2-1:0];

  fprot_range #(.SECT_W(SECT_W), .N_CHK(2)) u_range (
    .prot     (prot),
    .chk_sect (chk_sect),
    .chk_hit  (chk_hit),
    .lo       (prot_lo),
    .hi       (prot_hi)
  );

  assign dw_ok = dw_valid && !wr_hit;

  // interrupt status, mask and chip select
  logic [ISR_W-1:0] isr_q, isr_d;
  logic [ISR_W-1:0] imr_q;
  logic [CS_W-1:0]  cs_q;

  always_comb begin
    isr_d = isr_q;
    if (wr_isr) begin
      isr_d = isr_d & ~bus_wdata[ISR_W-1:0];
    end
    if (erase_viol) begin
      isr_d[ISR_ERASE] = 1'b1;
    end
    if (dw_valid && wr_hit) begin
      isr_d[ISR_WRITE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      isr_q <= '0;
      imr_q <= '0;
      cs_q  <= '0;
    end else begin
      isr_q <= isr_d;
      if (wr_imr) begin
        imr_q <= bus_wdata[ISR_W-1:0];
      end
      if (wr_cs) begin
        cs_q <= bus_wdata[CS_W-1:0];
      end
    end
  end

  assign chip_sel = cs_q;
  assign irq      = |(isr_q & imr_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (bus_addr)
        REG_STAT: bus_rdata = {25'b0, prot.level[3], prot.tb, prot.level[2:0], 2'b00};
        REG_SID:  bus_rdata = SID;
        REG_DID:  bus_rdata = DEVID;
        REG_ISR:  bus_rdata = {{(32-ISR_W){1'b0}}, isr_q};
        REG_IMR:  bus_rdata = {{(32-ISR_W){1'b0}}, imr_q};
        REG_CS:   bus_rdata = {{(32-CS_W){1'b0}}, cs_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R7: an issued sector erase never lies inside the protected range
  a_r7_sector_outside: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !req_bulk) |->
      (({1'b0, req_sector} < prot_lo) || ({1'b0, req_sector} >= prot_hi)));

  // R7: the erase flag only rises after a memory-operation write
  a_r7_erase_flag_src: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(isr_q[ISR_ERASE]) |-> $past(wr_memop));

  // R9: a blocked data write leaves its flag set
  a_r9_write_flag: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dw_valid && !dw_ok) |=> isr_q[ISR_WRITE]);

  // R10: flags hold unless cleared by a one written to them
  a_r10_erase_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    (isr_q[ISR_ERASE] && !(wr_isr && bus_wdata[ISR_ERASE])) |=> isr_q[ISR_ERASE]);

  a_r10_write_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    (isr_q[ISR_WRITE] && !(wr_isr && bus_wdata[ISR_WRITE])) |=> isr_q[ISR_WRITE]);

endmodule

// File: tb/fprot_csr_test.sv
module fprot_csr_test;

  localparam int ADDR_W = 19;
  localparam int SECT_W = 3;
  localparam int NSECT  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [2:0]        bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              dw_valid;
  logic [ADDR_W-1:0] dw_addr;
  logic              dw_ok, req_valid, req_bulk, irq;
  logic [SECT_W-1:0] req_sector;
  logic [2:0]        chip_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  fprot_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dw_valid(dw_valid), .dw_addr(dw_addr), .dw_ok(dw_ok),
    .req_valid(req_valid), .req_bulk(req_bulk), .req_sector(req_sector),
    .chip_sel(chip_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic bit prot_of(input int p, input int tb, input int s);
    int len;
    if (p == 0) len = 0;
    else if (p - 1 >= SECT_W) len = NSECT;
    else len = 1 << (p - 1);
    return (tb != 0) ? (s < len) : (s >= NSECT - len);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    dw_valid = 0; dw_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    rd(3'd0, v); chk("R12 status", v, 0);
    rd(3'd4, v); chk("R12 isr", v, 0);
    rd(3'd5, v); chk("R12 imr", v, 0);
    rd(3'd6, v); chk("R12 cs", v, 0);
    chk("R12 req_valid", req_valid, 0);
    chk("R12 irq", irq, 0);

    // R1: map
    rd(3'd1, v); chk("R1 sid", v, 32'h17);
    rd(3'd2, v); chk("R1 devid", v, 32'h19);
    rd(3'd3, v); chk("R1 memop reads 0", v, 0);
    rd(3'd7, v); chk("R1 offset 7", v, 0);
    wr(3'd6, 32'h5); rd(3'd6, v); chk("R1 cs rw", v, 5);
    chk("R1 chip_sel pin", chip_sel, 5);
    bus_addr = 3'd1; #1 chk("R1 no sel", bus_rdata, 0);
    wr(3'd5, 32'h3); rd(3'd5, v); chk("R11 imr rw", v, 3);

    // R2..R9 sweep over every level and anchor
    for (int tb = 0; tb < 2; tb++) begin
      for (int p = 0; p < 16; p++) begin
        wr(3'd3, (tb << 12) | (p << 8) | 3);
        rd(3'd0, v);
        chk("R2 R3 status", v, ((p >> 3) << 6) | (tb << 5) | ((p & 7) << 2));
        for (int s = 0; s < NSECT; s++) begin
          bit pr;
          pr = prot_of(p, tb, s);
          // R6 / R7 sector erase
          wr(3'd3, (s << 8) | 2);
          chk("R6 R7 req_valid", req_valid, !pr);
          if (!pr) begin
            chk("R6 req_sector", req_sector, s);
            chk("R6 req_bulk", req_bulk, 0);
          end
          rd(3'd4, v); chk("R7 isr erase", v, pr);
          chk("R11 irq", irq, pr);
          @(negedge clk);
          chk("R6 one cycle", req_valid, 0);
          wr(3'd4, 32'h3);
          // R9 / R4 / R5 data writes at both ends of the sector
          for (int e = 0; e < 2; e++) begin
            dw_valid = 1'b1;
            dw_addr  = ADDR_W'((s << 16) | (e ? 16'hFFFF : 0));
            #1 chk("R9 R4 R5 dw_ok", dw_ok, !pr);
            @(negedge clk);
            dw_valid = 1'b0;
            rd(3'd4, v); chk("R9 isr write", v, pr ? 2 : 0);
            wr(3'd4, 32'h3);
          end
        end
        // R8 bulk erase
        wr(3'd3, 1);
        chk("R8 bulk req", req_valid, p == 0);
        if (p == 0) chk("R8 bulk flag", req_bulk, 1);
        rd(3'd4, v); chk("R8 bulk isr", v, p != 0);
        wr(3'd4, 32'h3);
      end
    end

    // R10: partial clear, and set wins over clear
    wr(3'd3, 32'h0F03);
    wr(3'd3, 32'h0002);
    dw_valid = 1'b1; dw_addr = '0;
    @(negedge clk);
    dw_valid = 1'b0;
    rd(3'd4, v); chk("R10 both set", v, 3);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R10 partial clear", v, 2);
    dw_valid = 1'b1;
    wr(3'd4, 32'h2);
    dw_valid = 1'b0;
    rd(3'd4, v); chk("R10 set wins", v, 2);
    wr(3'd5, 32'h1);
    chk("R11 masked off", irq, 0);
    wr(3'd4, 32'h3);

    // R13: unknown opcodes
    wr(3'd3, 32'h1000);
    chk("R13 op0 no req", req_valid, 0);
    wr(3'd3, 32'h0107);
    chk("R13 op7 no req", req_valid, 0);
    rd(3'd0, v); chk("R13 status kept", v, 32'h5C);
    rd(3'd4, v); chk("R13 isr kept", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule